// File: doc/BRIEF.md
# Converter Reset-Calibrate-Convert Sequencer

This block is the control state machine of a sampling data converter. It puts the reset sequence, the calibration cycle and the conversion cycles in order. It drives an active-low ready flag. When a conversion finishes, it loads the result word in parallel into the output shift register. A latency stub stands in for the modulator and the decimation filter. The stub captures a raw 16-bit code when a conversion starts and returns it a fixed number of cycles later.

The logic that integrates the block samples the calibrate level on the clock edge that releases reset. That level decides whether a calibration runs on its own after the reset sequence. After that, a rising edge on calibrate while the block is idle starts a calibration. A low convert input starts a conversion whenever the block is idle. Because the convert input is level sensitive, holding it low chains conversions back to back, and the ready flag goes low for one cycle between them. The polarity select picks the output coding. In bipolar mode the result is two's complement. In unipolar mode it is plain binary over the range from zero to positive full scale.

Top module: `cvt_sequencer`

## Requirements
- R1: While `rst_n` is low on a clock edge, the edge leaves `rdy_n` = 1, `sr_load` = 0 and `sr_word` = 0, and it clears any pending calibration.
- R2: When `cal_req` was low on the last reset edge, `rdy_n` falls on the RST_CYC-th rising edge at which `rst_n` is high.
- R3: When `cal_req` was high on the last reset edge, a calibration follows the reset sequence. `rdy_n` stays high throughout and falls on edge RST_CYC+CAL_CYC after release.
- R4: A rising edge on `cal_req` seen while idle starts a calibration on that edge and sets `rdy_n` high. `rdy_n` falls CAL_CYC edges later.
- R5: `conv_n` = 0 seen while idle, with no calibration starting, starts a conversion and sets `rdy_n` high. CONV_CYC edges later, `sr_word` is loaded, `sr_load` pulses high for one cycle and `rdy_n` falls.
- R6: A low level on `conv_n` that ends before the block is idle again has no effect. It neither restarts nor extends a conversion or calibration, and no conversion follows it.
- R7: If `conv_n` is still low when `rdy_n` falls, the next edge starts a new conversion. `rdy_n` stays low for exactly one cycle between the two conversions.
- R8: With `bipolar` = 1 at the start edge, `sr_word` is the raw code with bit 15 inverted (two's complement). The raw code is `sample_in` as captured on the start edge.
- R9: With `bipolar` = 0 at the start edge, `sr_word` equals the raw code unchanged (straight binary).
- R10: An `rd_ack` pulse seen while idle sets `rdy_n` high on that edge.
- R11: A rising edge on `cal_req` during a conversion is held pending. The calibration starts on the edge after the conversion completes, so `rdy_n` is low for one cycle.
- R12: When a calibrate rising edge and `conv_n` = 0 are seen in the same idle cycle, the calibration runs and no conversion starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset of the converter |
| cal_req | input | 1 | Calibrate request; its level at reset release and its rising edges are used |
| conv_n | input | 1 | Active-low convert request, level sensitive |
| bipolar | input | 1 | 1 = two's complement output, 0 = straight binary |
| rd_ack | input | 1 | Readout-acknowledge pulse; returns ready high |
| sample_in | input | WORD_W | Raw code presented to the stub converter core |
| rdy_n | output | 1 | Active-low ready flag |
| sr_load | output | 1 | One-cycle parallel-load strobe for the output shift register |
| sr_word | output | WORD_W | Coded conversion word for the shift register |

## Verification
The embedded properties assume that every input is synchronous to `clk`. They also assume the stub core is only started while it is idle, which the sequencer itself guarantees. Reset-related checks assume `rst_n` is held for whole cycles. The bench changes every input only on the falling clock edge. It lowers `cal_req` for at least one cycle between requests, so each calibrate rising edge is distinct. It starts conversions, calibrations and acknowledges only in states where the requirements define the response.

// File: rtl/cvt_seq_pkg.sv
`timescale 1ns/1ps
// Shared types of the converter sequencer.
// Assumes: nothing beyond a synchronous single-clock design.
package cvt_seq_pkg;
    typedef enum logic [1:0] {
        PH_BOOT   = 2'd0,
        PH_TRIM   = 2'd1,
        PH_IDLE   = 2'd2,
        PH_SAMPLE = 2'd3
    } phase_t;
endpackage

// File: rtl/cvt_timer.sv
`timescale 1ns/1ps
// Down-counting interval timer. After reset it holds INIT; a load writes
// load_val. It decrements to zero and flags expire while the count is one,
// so an interval of N ends on the N-th edge after loading.
// Assumes: load_val >= 1.
module cvt_timer #(
    parameter int CW   = 9,
    parameter int INIT = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expire
);
    logic [CW-1:0] cnt;

    // Count register: preset, load or count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= CW'(INIT);
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expire = (cnt == CW'(1));

    assert_timer_drains_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !load) |=> (cnt == '0));
endmodule

// File: rtl/cvt_core_stub.sv
`timescale 1ns/1ps
// Stand-in for the modulator and the decimation filter. On start it captures
// the sample and raises done LAT edges later, with the captured code on raw.
// Assumes: start only arrives while the stub is idle; LAT >= 1.
module cvt_core_stub #(
    parameter int W   = 16,
    parameter int LAT = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] sample,
    output logic         done,
    output logic [W-1:0] raw
);
    localparam int CW = $clog2(LAT + 1);
    logic [CW-1:0] cnt;

    // Latency counter and sample capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            raw <= '0;
        end else if (start) begin
            cnt <= CW'(LAT);
            raw <= sample;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == CW'(1));

    assert_stub_idle_on_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (cnt == '0));
endmodule

// File: rtl/cvt_coder.sv
`timescale 1ns/1ps
// Output coding: inverting the sign bit turns the offset code into two's
// complement; unipolar passes the code through unchanged.
// Assumes: W >= 2.
module cvt_coder #(
    parameter int W = 16
) (
    input  logic         bipolar,
    input  logic [W-1:0] raw,
    output logic [W-1:0] code
);
    // Select the coding for the loaded word.
    always_comb begin
        if (bipolar) code = {~raw[W-1], raw[W-2:0]};
        else         code = raw;
    end
endmodule

// File: rtl/cvt_sequencer.sv
`timescale 1ns/1ps
// Reset / calibrate / convert sequencer of a sampling converter.
// It runs the reset sequence after rst_n rises, then an automatic calibration
// if cal_req was high on the last reset edge. After that it serves calibrate
// rising edges and low convert levels. Ready is active low and falls at the
// end of every cycle. Finished words go to the shift register through sr_load.
// Assumes: all inputs are synchronous to clk; RST_CYC, CAL_CYC and
// CONV_CYC >= 1.
module cvt_sequencer
    import cvt_seq_pkg::*;
#(
    parameter int RST_CYC  = 16,
    parameter int CAL_CYC  = 256,
    parameter int CONV_CYC = 64,
    parameter int WORD_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_req,
    input  logic              conv_n,
    input  logic              bipolar,
    input  logic              rd_ack,
    input  logic [WORD_W-1:0] sample_in,
    output logic              rdy_n,
    output logic              sr_load,
    output logic [WORD_W-1:0] sr_word
);
    localparam int TMAX = (RST_CYC > CAL_CYC) ? RST_CYC : CAL_CYC;
    localparam int TW   = $clog2(TMAX + 1);

    phase_t            phase;
    logic              cal_q, cal_auto, cal_pend, mode_q;
    logic              cal_rise, go_trim, go_sample, tmr_exp, core_done;
    logic [WORD_W-1:0] core_raw, coded;

    assign cal_rise = cal_req & ~cal_q;

    // Start decisions; calibration outranks conversion.
    always_comb begin
        go_trim   = ((phase == PH_IDLE) && (cal_pend || cal_rise)) ||
                    ((phase == PH_BOOT) && tmr_exp && cal_auto);
        go_sample = (phase == PH_IDLE) && !cal_pend && !cal_rise && !conv_n;
    end

    cvt_timer #(.CW(TW), .INIT(RST_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (go_trim),
        .load_val (TW'(CAL_CYC)),
        .expire   (tmr_exp)
    );

    cvt_core_stub #(.W(WORD_W), .LAT(CONV_CYC)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (go_sample),
        .sample (sample_in),
        .done   (core_done),
        .raw    (core_raw)
    );

    cvt_coder #(.W(WORD_W)) u_coder (
        .bipolar (mode_q),
        .raw     (core_raw),
        .code    (coded)
    );

    // Phase sequencing, ready flag and shift-register load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_BOOT;
            rdy_n    <= 1'b1;
            cal_q    <= cal_req;
            cal_auto <= cal_req;
            cal_pend <= 1'b0;
            mode_q   <= 1'b0;
            sr_load  <= 1'b0;
            sr_word  <= '0;
        end else begin
            cal_q   <= cal_req;
            sr_load <= 1'b0;
            unique case (phase)
                PH_BOOT: begin
                    if (tmr_exp) begin
                        if (cal_auto) begin
                            phase <= PH_TRIM;
                        end else begin
                            phase <= PH_IDLE;
                            rdy_n <= 1'b0;
                        end
                    end
                end
                PH_TRIM: begin
                    if (tmr_exp) begin
                        phase <= PH_IDLE;
                        rdy_n <= 1'b0;
                    end
                end
                PH_IDLE: begin
                    if (go_trim) begin
                        phase    <= PH_TRIM;
                        rdy_n    <= 1'b1;
                        cal_pend <= 1'b0;
                    end else if (go_sample) begin
                        phase  <= PH_SAMPLE;
                        rdy_n  <= 1'b1;
                        mode_q <= bipolar;
                    end else if (rd_ack) begin
                        rdy_n <= 1'b1;
                    end
                end
                PH_SAMPLE: begin
                    if (cal_rise) cal_pend <= 1'b1;
                    if (core_done) begin
                        phase   <= PH_IDLE;
                        rdy_n   <= 1'b0;
                        sr_load <= 1'b1;
                        sr_word <= coded;
                    end
                end
            endcase
        end
    end

    assert_busy_keeps_ready_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |-> rdy_n);
    assert_load_with_ready_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sr_load |-> (!rdy_n && phase == PH_IDLE));
    assert_ack_raises_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && rd_ack) |=> rdy_n);
    assert_pend_near_sample_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cal_pend |-> (phase == PH_SAMPLE || phase == PH_IDLE));
    assert_pend_served_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && cal_pend) |=> (phase == PH_TRIM));
    assert_held_convert_rearms_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !rdy_n && !conv_n && !cal_pend && !cal_rise)
        |=> (phase == PH_SAMPLE));
endmodule

// File: tb/cvt_sequencer_test.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared every cycle, plus directed checks.
module cvt_sequencer_test;
    localparam int RC = 16, CC = 256, VC = 64, W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0, cal = 1'b0, conv_n = 1'b1, bip = 1'b1, ack = 1'b0;
    logic [W-1:0] sample = '0;
    logic         rdy_n, sr_load;
    logic [W-1:0] sr_word;

    always #2.5 clk = ~clk;

    cvt_sequencer #(.RST_CYC(RC), .CAL_CYC(CC), .CONV_CYC(VC), .WORD_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .cal_req(cal), .conv_n(conv_n), .bipolar(bip),
        .rd_ack(ack), .sample_in(sample), .rdy_n(rdy_n), .sr_load(sr_load),
        .sr_word(sr_word)
    );

    int total = 0, bad = 0, cyc = 0;

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model: phase 0 boot, 1 calibrate, 2 idle, 3 convert.
    int    m_ph = 0, m_left = RC, m_rdy = 1, m_load = 0, m_word = 0;
    int    m_calq = 0, m_calr = 0, m_pend = 0, m_mode = 0, m_samp = 0;
    string m_tag = "R1";
    bit    live = 0;

    always @(posedge clk) begin : model_step
        bit rise;
        live   = 1;
        m_load = 0;
        if (!rst_n) begin
            m_ph = 0; m_left = RC; m_rdy = 1; m_word = 0;
            m_calq = cal; m_calr = cal; m_pend = 0; m_tag = "R1";
        end else begin
            rise   = cal && (m_calq == 0);
            m_calq = cal;
            case (m_ph)
                0: begin
                    m_left--;
                    if (m_left == 0) begin
                        if (m_calr != 0) begin m_ph = 1; m_left = CC; m_tag = "R3"; end
                        else begin m_ph = 2; m_rdy = 0; m_tag = "R2"; end
                    end
                end
                1: begin
                    m_left--;
                    if (m_left == 0) begin m_ph = 2; m_rdy = 0; end
                end
                3: begin
                    if (rise) m_pend = 1;
                    m_left--;
                    if (m_left == 0) begin
                        m_ph = 2; m_rdy = 0; m_load = 1; m_tag = "R5";
                        m_word = (m_mode != 0) ? (m_samp ^ 32'h8000) : m_samp;
                    end
                end
                default: begin
                    if (m_pend != 0 || rise) begin
                        m_tag = (m_pend != 0) ? "R11" : "R4";
                        m_pend = 0; m_ph = 1; m_left = CC; m_rdy = 1;
                    end else if (!conv_n) begin
                        m_ph = 3; m_left = VC; m_rdy = 1; m_mode = bip; m_samp = sample;
                        m_tag = "R5";
                    end else if (ack) begin
                        m_rdy = 1; m_tag = "R10";
                    end
                end
            endcase
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (live) begin
            check({m_tag, " ready"}, rdy_n, m_rdy);
            check({m_tag, " load"}, sr_load, m_load);
            check({m_tag, " word"}, sr_word, m_word);
        end
    end

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=finished", cyc);
            summary();
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_fall(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (rdy_n && n < 2000);
    endtask

    task automatic convert(input logic [W-1:0] s, input logic b, output int n);
        sample = s; bip = b; conv_n = 1'b0;
        @(negedge clk);
        conv_n = 1'b1; sample = ~s;
        wait_fall(n);
    endtask

    initial begin
        int n;
        tick(3);
        check("R1 ready in reset", rdy_n, 1);
        check("R1 load in reset", sr_load, 0);
        check("R1 word in reset", sr_word, 0);
        rst_n = 1'b1;
        wait_fall(n);
        check("R2 boot length", n, RC);

        convert(16'h1234, 1'b1, n);
        check("R5 conversion length", n, VC);
        check("R8 bipolar word", sr_word, 16'h9234);
        ack = 1'b1; @(negedge clk); ack = 1'b0;
        check("R10 ack raises ready", rdy_n, 1);
        convert(16'h0000, 1'b1, n);
        check("R8 bipolar zero code", sr_word, 16'h8000);
        convert(16'hFFFF, 1'b1, n);
        check("R8 bipolar top code", sr_word, 16'h7FFF);
        convert(16'hF00D, 1'b0, n);
        check("R9 unipolar word", sr_word, 16'hF00D);

        // R6: convert pulse during a conversion.
        sample = 16'h0C3A; bip = 1'b0; conv_n = 1'b0;
        @(negedge clk); conv_n = 1'b1;
        tick(5); conv_n = 1'b0; tick(2); conv_n = 1'b1;
        wait_fall(n);
        check("R6 conversion not restarted", n, VC - 7);
        check("R9 word after busy pulse", sr_word, 16'h0C3A);
        tick(4);
        check("R6 no conversion queued", rdy_n, 0);

        // R4 with a convert pulse inside the calibration (R6).
        cal = 1'b1; tick(10); conv_n = 1'b0; tick(2); conv_n = 1'b1;
        wait_fall(n);
        check("R4 calibration length", n, CC + 1 - 12);
        tick(3);
        check("R6 no conversion after calibration", rdy_n, 0);
        cal = 1'b0; tick(1);

        // R7 back-to-back conversions.
        sample = 16'h00AA; bip = 1'b0; conv_n = 1'b0;
        wait_fall(n);
        check("R5 first chained conversion", n, VC + 1);
        @(negedge clk);
        check("R7 ready low one cycle", rdy_n, 1);
        wait_fall(n);
        check("R7 second conversion length", n, VC);
        conv_n = 1'b1;
        tick(2);
        check("R7 chain stops", rdy_n, 0);

        // R11 calibrate request during conversion.
        sample = 16'h0042; bip = 1'b0; conv_n = 1'b0;
        @(negedge clk); conv_n = 1'b1;
        tick(3); cal = 1'b1;
        wait_fall(n);
        check("R11 conversion unaffected", n, VC - 3);
        check("R9 word before pending cal", sr_word, 16'h0042);
        @(negedge clk);
        check("R11 pending cal starts", rdy_n, 1);
        wait_fall(n);
        check("R11 pending cal length", n, CC);
        cal = 1'b0; tick(1);

        // R12 calibrate outranks convert.
        cal = 1'b1; conv_n = 1'b0;
        @(negedge clk); conv_n = 1'b1;
        wait_fall(n);
        check("R12 calibration chosen", n, CC);
        check("R12 word unchanged", sr_word, 16'h0042);
        cal = 1'b0;

        // R3 automatic calibration after reset.
        rst_n = 1'b0; cal = 1'b1; tick(3);
        check("R1 ready in second reset", rdy_n, 1);
        check("R1 word cleared", sr_word, 0);
        rst_n = 1'b1;
        wait_fall(n);
        check("R3 boot plus calibration", n, RC + CC);
        cal = 1'b0;
        tick(2);
        summary();
    end
endmodule